// File: doc/BRIEF.md
# Shared Underload Delay Timer

This block detects open loads on a set of half-bridge driver channels. Every channel brings in an underload comparator result, and that result counts only while the channel's driver is commanded on. One delay timer serves all channels. It starts when the first qualified underload appears on any channel and keeps counting for as long as at least one channel is still in qualified underload. It expires after a fixed number of clock cycles. On expiry it sets a sticky underload flag. If the shutdown enable is high, it also latches off every channel that is in qualified underload at that moment.

A channel that enters underload while the timer is already running does not get a fresh delay. It is caught when the running timer expires, so it waits only for the time that remains. After expiry, and while underload continues, any further channel that becomes underloaded is caught on the next clock. When no channel has a qualified underload, the timer returns to zero. A status-reset strobe clears the flag and all latch-offs and restarts the timer from zero. The protection controller uses the latch-off outputs to hold the affected drivers off.

The timer is a three-state machine. The states are `TMR_IDLE` (count at zero), `TMR_TIMING` (counting) and `TMR_EXPIRED` (delay used up). Its transitions are:
- start: `TMR_IDLE`→`TMR_TIMING` on any qualified underload.
- advance: `TMR_TIMING` holds and counts while underload persists.
- expire: `TMR_TIMING`→`TMR_EXPIRED` on the last delay cycle.
- drop: `TMR_TIMING` or `TMR_EXPIRED`→`TMR_IDLE` when no qualified underload remains.
- clear: any state→`TMR_IDLE` on the status-reset strobe.

Top module: `uld_shared_timer`

## Requirements
- R1: Bit i of `uld_raw` counts as underload only while bit i of `drv_on` is 1. With `drv_on` low, the raw input has no effect on the timer, the flag or the latch-offs.
- R2: The flag becomes 1 at the clock edge that samples the DELAY_CYCLES-th consecutive cycle with at least one qualified underload. It is visible right after that edge. A run shorter than DELAY_CYCLES leaves the flag at 0.
- R3: One sampled cycle with no qualified underload on any channel resets the timer to zero. The next underload then needs a full DELAY_CYCLES run.
- R4: A channel whose underload begins after the timer has started is flagged and latched at the expiry of that same timer. It is not given a fresh full delay.
- R5: The timer keeps counting across a handover, where one channel's underload ends in the same cycle that another's begins.
- R6: Once the timer has expired, and while qualified underload persists, a channel that newly enters underload is latched on the next clock edge.
- R7: Latch-off bit i (`drv_latch_off[i]`) is set only when `uld_shutdown_en` is 1 at a catching edge and channel i is in qualified underload then. With `uld_shutdown_en` at 0, only the flag is set. A set latch-off bit implies the flag is set.
- R8: The flag and the set latch-off bits stay set until a status-reset strobe, even after the underload ends.
- R9: A `status_clr` cycle clears the flag and all latch-offs and returns the timer to zero. It wins over an expiry in the same cycle.
- R10: After reset the flag and all latch-offs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drv_on | input | NUM_CH | Driver commanded on, per channel |
| uld_raw | input | NUM_CH | Underload comparator result, per channel |
| uld_shutdown_en | input | 1 | 1: latch off the underloaded channels on expiry |
| status_clr | input | 1 | Status-reset strobe, one cycle |
| uld_flag | output | 1 | Sticky underload status |
| drv_latch_off | output | NUM_CH | Sticky latch-off request, per channel |

## Verification
The checker watches four properties on every cycle. The flag and latch-off bits are sticky. A clear wipes them. A latch-off bit never appears without qualified underload on that channel in the cycle before, nor while shutdown is disabled. The flag never rises without qualified underload one cycle earlier. The exact expiry cycle can only be shown by the bench's scenarios. These cover the remaining-time rule for a late channel, the handover between channels, the restart after a one-cycle gap and the full-delay restart after a clear. The bench sweeps run lengths, channel masks and join offsets for this purpose.

// File: rtl/uld_pkg.sv
package uld_pkg;

    typedef enum logic [1:0] {
        TMR_IDLE    = 2'd0,
        TMR_TIMING  = 2'd1,
        TMR_EXPIRED = 2'd2
    } tmr_state_t;

endpackage

// File: rtl/uld_qualify.sv
module uld_qualify #(
    parameter int NUM_CH = 3
) (
    input  logic [NUM_CH-1:0] drv_on,
    input  logic [NUM_CH-1:0] uld_raw,
    output logic [NUM_CH-1:0] qual,
    output logic              any_qual
);

    // A comparator result is meaningful only while the driver is on.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign qual[ch] = uld_raw[ch] & drv_on[ch];
    end

    assign any_qual = |qual;

endmodule

// File: rtl/uld_delay_timer.sv
module uld_delay_timer
    import uld_pkg::*;
#(
    parameter int DELAY_CYCLES = 700,
    parameter int CNT_W        = (DELAY_CYCLES > 2) ? $clog2(DELAY_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_qual,
    input  logic clr,
    output logic trip
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DELAY_CYCLES - 1);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    tmr_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMR_IDLE: begin
                if (any_qual) begin              // start
                    state_d = TMR_TIMING;
                    cnt_d   = ONE_CNT;
                end
            end
            TMR_TIMING: begin
                if (!any_qual) begin             // drop
                    state_d = TMR_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == LAST_CNT) begin
                    state_d = TMR_EXPIRED;       // expire
                end else begin
                    cnt_d   = cnt_q + ONE_CNT;   // advance
                end
            end
            TMR_EXPIRED: begin
                if (!any_qual) begin             // drop
                    state_d = TMR_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = TMR_IDLE;
                cnt_d   = '0;
            end
        endcase
        if (clr) begin                           // clear
            state_d = TMR_IDLE;
            cnt_d   = '0;
        end
    end

    // Outputs: catch on the final delay cycle and every cycle after it
    always_comb begin
        trip = 1'b0;
        unique case (state_q)
            TMR_TIMING:  trip = any_qual && (cnt_q == LAST_CNT);
            TMR_EXPIRED: trip = any_qual;
            default:     trip = 1'b0;
        endcase
        if (clr) trip = 1'b0;
    end

endmodule

// File: rtl/uld_fault_latch.sv
module uld_fault_latch #(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              trip,
    input  logic              shut_en,
    input  logic [NUM_CH-1:0] qual,
    output logic              flag,
    output logic [NUM_CH-1:0] latch_off
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (clr) begin
            flag <= 1'b0;
        end else if (trip) begin
            flag <= 1'b1;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                latch_off[ch] <= 1'b0;
            end else if (clr) begin
                latch_off[ch] <= 1'b0;
            end else if (trip && shut_en && qual[ch]) begin
                latch_off[ch] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/uld_shared_timer.sv
module uld_shared_timer #(
    parameter int NUM_CH       = 3,
    parameter int DELAY_CYCLES = 700
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] drv_on,
    input  logic [NUM_CH-1:0] uld_raw,
    input  logic              uld_shutdown_en,
    input  logic              status_clr,
    output logic              uld_flag,
    output logic [NUM_CH-1:0] drv_latch_off
);

    logic [NUM_CH-1:0] qual;
    logic              any_qual;
    logic              trip;

    uld_qualify #(.NUM_CH(NUM_CH)) u_qual (
        .drv_on   (drv_on),
        .uld_raw  (uld_raw),
        .qual     (qual),
        .any_qual (any_qual)
    );

    uld_delay_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_qual (any_qual),
        .clr      (status_clr),
        .trip     (trip)
    );

    uld_fault_latch #(.NUM_CH(NUM_CH)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (status_clr),
        .trip      (trip),
        .shut_en   (uld_shutdown_en),
        .qual      (qual),
        .flag      (uld_flag),
        .latch_off (drv_latch_off)
    );

endmodule

// File: rtl/uld_checker.sv
module uld_checker #(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] drv_on,
    input logic [NUM_CH-1:0] uld_raw,
    input logic              uld_shutdown_en,
    input logic              status_clr,
    input logic              uld_flag,
    input logic [NUM_CH-1:0] drv_latch_off
);

    AST_LATCH_IMPLIES_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (|drv_latch_off) |-> uld_flag);                                    // R7

    AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        status_clr |=> (!uld_flag && drv_latch_off == '0));                // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (uld_flag && !status_clr) |=> uld_flag);                           // R8

    AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !status_clr |=> ((drv_latch_off & $past(drv_latch_off)) == $past(drv_latch_off))); // R8

    AST_DISABLED_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_clr && !uld_shutdown_en) |=> (drv_latch_off == $past(drv_latch_off))); // R7

    AST_LATCH_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !status_clr |=> ((drv_latch_off & ~$past(drv_latch_off) & ~$past(uld_raw & drv_on)) == '0)); // R1

    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uld_flag) |-> $past(|(uld_raw & drv_on)));                   // R2

endmodule

bind uld_shared_timer uld_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .drv_on          (drv_on),
    .uld_raw         (uld_raw),
    .uld_shutdown_en (uld_shutdown_en),
    .status_clr      (status_clr),
    .uld_flag        (uld_flag),
    .drv_latch_off   (drv_latch_off)
);

// File: tb/uld_shared_timer_test.sv
module uld_shared_timer_test;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 3;
    localparam int D          = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] drv_on = '1;
    logic [N-1:0] uld_raw = '0;
    logic         uld_shutdown_en = 1'b1;
    logic         status_clr = 1'b0;
    logic         uld_flag;
    logic [N-1:0] drv_latch_off;

    int vec_cnt = 0;
    int bad_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uld_shared_timer #(.NUM_CH(N), .DELAY_CYCLES(D)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .drv_on          (drv_on),
        .uld_raw         (uld_raw),
        .uld_shutdown_en (uld_shutdown_en),
        .status_clr      (status_clr),
        .uld_flag        (uld_flag),
        .drv_latch_off   (drv_latch_off)
    );

    // Outputs are sampled at the falling edge, after each rising edge settles.
    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic exp_flag, logic [N-1:0] exp_lat);
        vec_cnt++;
        if ({uld_flag, drv_latch_off} !== {exp_flag, exp_lat}) begin
            bad_cnt++;
            $display("FAIL %s actual flag=%0b latch=%03b expected flag=%0b latch=%03b",
                     req, uld_flag, drv_latch_off, exp_flag, exp_lat);
        end
    endtask

    task automatic do_clear();
        uld_raw    = '0;
        status_clr = 1'b1;
        tick();
        status_clr = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad_cnt++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick();
        chk("R10 reset state", 1'b0, '0);

        // R2/R7/R8: run-length sweep over masks and shutdown enable
        for (int en = 0; en < 2; en++) begin
            for (int m = 1; m < (1 << N); m++) begin
                for (int len = 1; len <= D + 1; len++) begin
                    logic          hit;
                    logic [N-1:0]  lat;
                    do_clear();
                    drv_on          = '1;
                    uld_shutdown_en = en[0];
                    uld_raw         = m[N-1:0];
                    tick(len);
                    hit = (len >= D);
                    lat = (hit && en == 1) ? m[N-1:0] : '0;
                    chk("R2 run length", hit, lat);
                    uld_raw = '0;
                    tick(2);
                    chk("R8 sticky after removal", hit, lat);
                end
            end
        end
        uld_shutdown_en = 1'b1;

        // R4: late joiner waits only the remainder
        for (int k = 1; k < D; k++) begin
            do_clear();
            uld_raw = 3'b001;
            tick(k);
            uld_raw = 3'b011;
            tick(D - 1 - k);
            chk("R4 before expiry", 1'b0, '0);
            tick();
            chk("R4 joiner caught at expiry", 1'b1, 3'b011);
        end

        // R5: handover keeps the timer running
        for (int k = 1; k < D; k++) begin
            do_clear();
            uld_raw = 3'b001;
            tick(k);
            uld_raw = 3'b010;
            tick(D - k);
            chk("R5 handover", 1'b1, 3'b010);
        end

        // R3: single idle cycle restarts the count
        for (int g = 1; g < D; g++) begin
            do_clear();
            uld_raw = 3'b100;
            tick(g);
            uld_raw = 3'b000;
            tick();
            uld_raw = 3'b100;
            tick(D - 1);
            chk("R3 no expiry after gap", 1'b0, '0);
            tick();
            chk("R3 full delay after gap", 1'b1, 3'b100);
        end

        // R6: channel entering after expiry is caught next clock
        do_clear();
        uld_raw = 3'b001;
        tick(D);
        chk("R6 first expiry", 1'b1, 3'b001);
        uld_raw = 3'b101;
        tick();
        chk("R6 post-expiry joiner", 1'b1, 3'b101);

        // R1: raw ignored while driver off
        do_clear();
        drv_on  = 3'b000;
        uld_raw = 3'b111;
        tick(2 * D);
        chk("R1 drivers off", 1'b0, '0);
        drv_on = 3'b010;
        tick(D);
        chk("R1 only on channel", 1'b1, 3'b010);
        do_clear();
        drv_on  = 3'b001;
        uld_raw = 3'b001;
        tick(D - 1);
        drv_on = 3'b000;
        tick();
        drv_on = 3'b001;
        tick(D - 1);
        chk("R1 off cycle resets timer", 1'b0, '0);
        drv_on = '1;

        // R9: clear wins over expiry and restarts a full delay
        do_clear();
        uld_raw = 3'b001;
        tick(D);
        chk("R9 set before clear", 1'b1, 3'b001);
        status_clr = 1'b1;
        tick();
        status_clr = 1'b0;
        chk("R9 clear wins", 1'b0, '0);
        tick(D - 1);
        chk("R9 no early re-flag", 1'b0, '0);
        tick();
        chk("R9 re-flag after full delay", 1'b1, 3'b001);

        do_clear();
        chk("R9 cleared", 1'b0, '0);
        finish_run();
    end

endmodule